// File: doc/BRIEF.md
# Backplane Integer ALU Card

This block is the arithmetic-logic card of a processor built from cards on a shared backplane. Every card sees the same two 32-bit operand buses, A and B, and a single 32-bit result bus, Y. Three operation-type lines say what the current cycle is for: an ALU operation, a memory read or a memory write. When the cycle is an ALU operation, the card combines A and B and places the result on Y.

A 3-bit function code selects the operation. One more function bit, carried on its own line, picks between the two variants that share code 000 (add or subtract) and code 101 (logical or arithmetic right shift). The result is purely combinational from the bus inputs. It is therefore ready to be captured by the register card at the next rising edge of the master clock.

The card owns Y only during ALU cycles. At every other time it raises no drive enable and holds its Y output at zero, so the bus can be shared by wired-OR or by a mux.

Top module: `alu_card`

## Requirements
- R1: `y_drive` is 1 exactly when `op_alu` is 1 and both `op_mem_rd` and `op_mem_wr` are 0; any asserted memory line forces it to 0.
- R2: While `y_drive` is 0, `y_bus` is all zeros, whatever the function code and operands.
- R3: Function 000 gives A+B when `func_alt` is 0 and A-B when `func_alt` is 1, both modulo 2^32.
- R4: Function 001 shifts A left by B[4:0], filling with zeros; B[31:5] has no effect.
- R5: Function 010 gives 1 if A is less than B as signed two's-complement numbers, else 0; bits 31..1 of the result are 0.
- R6: Function 011 gives 1 if A is less than B as unsigned numbers, else 0.
- R7: Function 100 gives A xor B, function 110 gives A or B, and function 111 gives A and B.
- R8: Function 101 shifts A right by B[4:0]: zero fill when `func_alt` is 0, sign fill from A[31] when `func_alt` is 1.
- R9: `func_alt` has no effect for functions 001, 010, 011, 100, 110 and 111.
- R10: The result depends only on the current inputs. It is valid in the same cycle, and it is the value seen at the next rising clock edge while the inputs stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane master clock, rising edge |
| rst | input | 1 | Synchronous active-high reset (used to qualify checks) |
| op_alu | input | 1 | Operation type: ALU |
| op_mem_rd | input | 1 | Operation type: memory read |
| op_mem_wr | input | 1 | Operation type: memory write |
| func | input | 3 | Function code |
| func_alt | input | 1 | Extra function bit (subtract / arithmetic shift) |
| a_bus | input | 32 | First operand bus |
| b_bus | input | 32 | Second operand bus |
| y_bus | output | 32 | Result toward the Y bus, zero when not driving |
| y_drive | output | 1 | Y bus drive enable |

## Verification
The assertions are sampled at rising clock edges. They assume the operation-type lines, function code and operand buses are settled there, as the synchronous backplane guarantees. The bench changes every input on the falling edge and never near a rising edge. It also covers combinations of type lines that a well-behaved sequencer would not send, such as ALU together with a memory line, so the bus-ownership properties are exercised against conflicting requests.

// File: rtl/alu_card_pkg.sv
package alu_card_pkg;

    localparam int XLEN = 32;

    typedef enum logic [2:0] {
        FN_ADDSUB = 3'b000,
        FN_SLL    = 3'b001,
        FN_SLT    = 3'b010,
        FN_SLTU   = 3'b011,
        FN_XOR    = 3'b100,
        FN_SHR    = 3'b101,
        FN_OR     = 3'b110,
        FN_AND    = 3'b111
    } alu_fn_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    sub;
        logic    shl;
        logic    sar;
        logic    drive;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_ctrl(
        input logic       is_alu,
        input logic       is_rd,
        input logic       is_wr,
        input logic [2:0] code,
        input logic       alt
    );
        alu_ctrl_t c;
        c.fn    = alu_fn_e'(code);
        c.sub   = (c.fn == FN_ADDSUB) && alt;
        c.shl   = (c.fn == FN_SLL);
        c.sar   = (c.fn == FN_SHR) && alt;
        c.drive = is_alu && !is_rd && !is_wr;
        return c;
    endfunction

    function automatic logic [XLEN-1:0] flag_word(input logic f);
        return {{(XLEN-1){1'b0}}, f};
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] b_eff;
    logic [W-1:0] carry_in;

    always_comb begin
        b_eff    = sub ? ~b : b;
        carry_in = {{(W-1){1'b0}}, sub};
        sum      = a + b_eff + carry_in;
    end

    // R3: subtracting equal operands yields zero
    a_r3_sub_self_zero: assert property (@(posedge clk) disable iff (rst)
        (sub && a == b) |-> (sum == '0));
    // R3: adding zero leaves A unchanged
    a_r3_add_identity: assert property (@(posedge clk) disable iff (rst)
        (!sub && b == '0) |-> (sum == a));
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    input  logic           left,
    input  logic           arith,
    output logic [W-1:0]   dout
);
    logic [W-1:0] stage [0:SHW];
    logic [W-1:0] rev_in;
    logic         fill;

    assign fill = arith && !left && din[W-1];

    for (genvar i = 0; i < W; i++) begin : g_rev_in
        assign rev_in[i] = left ? din[W-1-i] : din[i];
    end

    assign stage[0] = rev_in;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k]
            ? {{STEP{fill}}, stage[k][W-1:STEP]}
            : stage[k];
    end

    for (genvar i = 0; i < W; i++) begin : g_rev_out
        assign dout[i] = left ? stage[SHW][W-1-i] : stage[SHW][i];
    end

    // R4/R8: a zero shift amount passes the operand through
    a_r8_zero_shift_identity: assert property (@(posedge clk) disable iff (rst)
        (amt == '0) |-> (dout == din));
    // R8: a logical right shift by a nonzero amount clears the top bit
    a_r8_logical_top_clear: assert property (@(posedge clk) disable iff (rst)
        (!left && !arith && amt != '0) |-> (dout[W-1] == 1'b0));
    // R4: a nonzero left shift clears bit 0
    a_r4_left_low_clear: assert property (@(posedge clk) disable iff (rst)
        (left && amt != '0) |-> (dout[0] == 1'b0));
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt_s,
    output logic         lt_u
);
    always_comb begin
        lt_u = (a < b);
        lt_s = (a[W-1] != b[W-1]) ? a[W-1] : lt_u;
    end

    // R5/R6: equal operands are never less-than
    a_r5_equal_not_less: assert property (@(posedge clk) disable iff (rst)
        (a == b) |-> (!lt_s && !lt_u));
    // R6: same sign means signed and unsigned orderings agree
    a_r6_same_sign_agree: assert property (@(posedge clk) disable iff (rst)
        (a[W-1] == b[W-1]) |-> (lt_s == lt_u));
endmodule

// File: rtl/alu_card.sv
module alu_card
    import alu_card_pkg::*;
#(
    parameter int W   = alu_card_pkg::XLEN,
    parameter int SHW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_alu,
    input  logic         op_mem_rd,
    input  logic         op_mem_wr,
    input  logic [2:0]   func,
    input  logic         func_alt,
    input  logic [W-1:0] a_bus,
    input  logic [W-1:0] b_bus,
    output logic [W-1:0] y_bus,
    output logic         y_drive
);
    alu_ctrl_t    ctrl;
    logic [W-1:0] sum;
    logic [W-1:0] shifted;
    logic         lt_s;
    logic         lt_u;
    logic [W-1:0] result;

    assign ctrl = decode_ctrl(op_alu, op_mem_rd, op_mem_wr, func, func_alt);

    alu_addsub #(.W(W)) u_addsub (
        .clk (clk),
        .rst (rst),
        .a   (a_bus),
        .b   (b_bus),
        .sub (ctrl.sub),
        .sum (sum)
    );

    alu_shift #(.W(W), .SHW(SHW)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .din   (a_bus),
        .amt   (b_bus[SHW-1:0]),
        .left  (ctrl.shl),
        .arith (ctrl.sar),
        .dout  (shifted)
    );

    alu_compare #(.W(W)) u_compare (
        .clk  (clk),
        .rst  (rst),
        .a    (a_bus),
        .b    (b_bus),
        .lt_s (lt_s),
        .lt_u (lt_u)
    );

    always_comb begin
        case (ctrl.fn)
            FN_ADDSUB: result = sum;
            FN_SLL:    result = shifted;
            FN_SLT:    result = {{(W-1){1'b0}}, lt_s};
            FN_SLTU:   result = {{(W-1){1'b0}}, lt_u};
            FN_XOR:    result = a_bus ^ b_bus;
            FN_SHR:    result = shifted;
            FN_OR:     result = a_bus | b_bus;
            FN_AND:    result = a_bus & b_bus;
            default:   result = '0;
        endcase
    end

    assign y_drive = ctrl.drive;
    assign y_bus   = ctrl.drive ? result : '0;

    // R1: a memory cycle never sees this card on Y
    a_r1_mem_release: assert property (@(posedge clk) disable iff (rst)
        (op_mem_rd || op_mem_wr) |-> !y_drive);
    // R1: drive only with the ALU line high
    a_r1_needs_alu: assert property (@(posedge clk) disable iff (rst)
        y_drive |-> op_alu);
    // R2: released bus output is all zeros
    a_r2_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
        !y_drive |-> (y_bus == '0));
    // R5/R6: compare results carry only bit 0
    a_r5_flag_only: assert property (@(posedge clk) disable iff (rst)
        (y_drive && (func == FN_SLT || func == FN_SLTU)) |-> (y_bus[W-1:1] == '0));
    // R7: and-result never has a bit that or-result lacks (checked on live ops)
    a_r7_and_subset: assert property (@(posedge clk) disable iff (rst)
        (y_drive && func == FN_AND) |-> ((y_bus & ~(a_bus | b_bus)) == '0));
endmodule

// File: tb/test_alu_card.sv
module test_alu_card;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_alu, op_mem_rd, op_mem_wr;
    logic [2:0]  func;
    logic        func_alt;
    logic [31:0] a_bus, b_bus;
    logic [31:0] y_bus;
    logic        y_drive;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    alu_card i_alu_card (
        .clk       (clk),
        .rst       (rst),
        .op_alu    (op_alu),
        .op_mem_rd (op_mem_rd),
        .op_mem_wr (op_mem_wr),
        .func      (func),
        .func_alt  (func_alt),
        .a_bus     (a_bus),
        .b_bus     (b_bus),
        .y_bus     (y_bus),
        .y_drive   (y_drive)
    );

    function automatic logic [31:0] model(input logic [2:0] f, input logic alt,
                                          input logic [31:0] a, input logic [31:0] b);
        case (f)
            3'b000: return alt ? a - b : a + b;
            3'b001: return a << b[4:0];
            3'b010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'b011: return (a < b) ? 32'd1 : 32'd0;
            3'b100: return a ^ b;
            3'b101: return alt ? 32'($signed(a) >>> b[4:0]) : a >> b[4:0];
            3'b110: return a | b;
            default: return a & b;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic alu, input logic rd, input logic wr,
                         input logic [2:0] f, input logic alt,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_alu = alu; op_mem_rd = rd; op_mem_wr = wr;
        func = f; func_alt = alt; a_bus = a; b_bus = b;
        #1;
    endtask

    task automatic run_op(input string tag, input logic [2:0] f, input logic alt,
                          input logic [31:0] a, input logic [31:0] b);
        apply(1'b1, 1'b0, 1'b0, f, alt, a, b);
        check({tag, " result"}, y_bus, model(f, alt, a, b));
        check({tag, " drive"}, {31'd0, y_drive}, 32'd1);
    endtask

    task automatic t_reset_state();
        check("reset R1 drive", {31'd0, y_drive}, 32'd0);
        check("reset R2 y", y_bus, 32'd0);
    endtask

    task automatic t_ownership();
        // R1/R2: every type-line combination other than pure ALU releases Y
        for (int m = 0; m < 8; m++) begin
            apply(m[0], m[1], m[2], 3'b110, 1'b0, 32'hF0F0_1234, 32'h0F0F_8001);
            if (m == 1) begin
                check("R1 pure alu drives", {31'd0, y_drive}, 32'd1);
                check("R2 pure alu value", y_bus, 32'hFFFF_9235);
            end else begin
                check("R1 release", {31'd0, y_drive}, 32'd0);
                check("R2 zero when released", y_bus, 32'd0);
            end
        end
    endtask

    task automatic t_addsub();
        run_op("R3 add", 3'b000, 1'b0, 32'd100, 32'd23);
        run_op("R3 add wrap", 3'b000, 1'b0, 32'hFFFF_FFFF, 32'd2);
        run_op("R3 sub", 3'b000, 1'b1, 32'd5, 32'd7);
        run_op("R3 sub min", 3'b000, 1'b1, 32'h8000_0000, 32'd1);
    endtask

    task automatic t_shifts();
        run_op("R4 sll", 3'b001, 1'b0, 32'h8000_0001, 32'd4);
        run_op("R4 sll 31", 3'b001, 1'b0, 32'h0000_0003, 32'd31);
        run_op("R4 sll upper b ignored", 3'b001, 1'b0, 32'h0000_00FF, 32'hFFFF_FFE3);
        run_op("R8 srl", 3'b101, 1'b0, 32'h8000_0000, 32'd31);
        run_op("R8 sra", 3'b101, 1'b1, 32'h8000_0000, 32'd31);
        run_op("R8 sra positive", 3'b101, 1'b1, 32'h4000_0000, 32'd4);
        run_op("R8 shift zero", 3'b101, 1'b1, 32'hDEAD_BEEF, 32'h0000_0020);
    endtask

    task automatic t_compares();
        run_op("R5 slt neg<pos", 3'b010, 1'b0, 32'hFFFF_FFFF, 32'd1);
        run_op("R5 slt pos>neg", 3'b010, 1'b0, 32'd1, 32'hFFFF_FFFF);
        run_op("R5 slt equal", 3'b010, 1'b0, 32'd9, 32'd9);
        run_op("R6 sltu big", 3'b011, 1'b0, 32'hFFFF_FFFF, 32'd1);
        run_op("R6 sltu small", 3'b011, 1'b0, 32'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_logic();
        run_op("R7 xor", 3'b100, 1'b0, 32'hAAAA_5555, 32'hFFFF_0000);
        run_op("R7 or", 3'b110, 1'b0, 32'h1200_0034, 32'h0056_7800);
        run_op("R7 and", 3'b111, 1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00);
    endtask

    task automatic t_alt_ignored();
        // R9: alt bit flips must not change these functions
        logic [2:0] codes [6] = '{3'b001, 3'b010, 3'b011, 3'b100, 3'b110, 3'b111};
        foreach (codes[i]) begin
            apply(1'b1, 1'b0, 1'b0, codes[i], 1'b1, 32'h8765_4321, 32'h0000_0F05);
            check("R9 alt ignored", y_bus, model(codes[i], 1'b0, 32'h8765_4321, 32'h0000_0F05));
        end
    endtask

    task automatic t_edge_capture();
        // R10: value seen at the next rising edge equals the combinational result
        logic [31:0] captured;
        apply(1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 32'h1111_1111, 32'h2222_2222);
        check("R10 same cycle", y_bus, 32'h3333_3333);
        @(posedge clk);
        #1;
        captured = y_bus;
        check("R10 at edge", captured, 32'h3333_3333);
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        op_alu = 1'b0; op_mem_rd = 1'b0; op_mem_wr = 1'b0;
        func = 3'b000; func_alt = 1'b0; a_bus = '0; b_bus = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset_state();
        @(negedge clk);
        rst = 1'b0;
        t_ownership();
        t_addsub();
        t_shifts();
        t_compares();
        t_logic();
        t_alt_ignored();
        t_edge_capture();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule